// File: doc/BRIEF.md
# Compare-and-Branch and Relative-Call Sequencer

This unit carries out two multi-cycle jobs for an 8-bit processor core. The core has an accumulator A, a 16-bit index pair H:X whose low byte is X, a 16-bit stack pointer SP and a 16-bit program counter. The first job compares A or X with an operand and redirects the program counter by a signed 8-bit displacement when the two are equal. The operand comes from one of six addressing forms. The second job is a relative subroutine call. It writes the 16-bit return address to the stack and then jumps.

The core pulses `start` once it has fetched the opcode, plus the prefix byte if there is one. With that pulse it supplies `op`, the `pfx` flag, `pc_in` (the address of the byte just after the opcode) and the current A, H:X and SP values. The unit latches these and fetches its own operand bytes through a program-byte port whose data is returned in the same cycle. It reads memory through a data read port that also answers in the same cycle, and it writes the stack through a write port. When it finishes it pulses `done`. In that cycle `pc_out`, `hx_out`, `sp_out` and `taken` hold the new register values. The condition flags are never computed or changed.

The sequencer is a single state machine. Its states are IDLE, PUSH_LO, PUSH_HI, FETCH1, FETCH2, READ, PAD and DONE.

| Transition | Condition |
|---|---|
| IDLE to PUSH_LO | call accepted |
| IDLE to FETCH1 | compare form accepted |
| PUSH_LO to PUSH_HI | always |
| PUSH_HI to FETCH1 | always |
| FETCH1 to DONE | call |
| FETCH1 to READ | post-increment form without an offset |
| FETCH1 to FETCH2 | every other form |
| FETCH2 to DONE | immediate forms |
| FETCH2 to READ | memory forms |
| READ to PAD | forms without an offset post-increment, and the stack-relative form |
| READ to DONE | direct and offset post-increment forms |
| PAD to DONE | always |
| DONE to IDLE | always |

Top module: `cmpbr_call_seq`

## Requirements
- R1: The accepted encodings are 0x31, 0x41, 0x51, 0x61, 0x71 and 0xAD with `pfx`=0, plus 0x61 with `pfx`=1. A `start` carrying any other combination is ignored: `busy` stays low and `done` never pulses.
- R2: Counting the `start` cycle as cycle 1, `done` is high in cycle N, where N is as follows:
  - 0x31: 5
  - 0x41: 4
  - 0x51: 4
  - 0x61: 5
  - 0x71: 5
  - prefixed 0x61: 6
  - 0xAD: 5
- R3: For a compare form, `taken` is 1 exactly when the compared register equals the operand. `pc_out` is then the fall-through address plus the sign-extended displacement; otherwise it is the fall-through address. The fall-through address is `pc_in`+1 for 0x71 and `pc_in`+2 for the other compare forms.
- R4: Operand bytes are fetched in order starting at `pc_in`. The operand sources are:
  - 0x41: the byte at `pc_in`, compared with A.
  - 0x51: the byte at `pc_in`, compared with X.
  - 0x31: memory at the zero-extended byte at `pc_in`, compared with A.
  - 0x61: memory at H:X plus that unsigned byte, compared with A.
  - Prefixed 0x61: memory at SP plus that unsigned byte, compared with A.
  - 0x71: memory at H:X, compared with A.

  The displacement is the byte after the offset byte. For 0x71 it is the byte at `pc_in`.
- R5: 0x61 and 0x71 without the prefix return `hx_out` = H:X+1, whether or not the branch is taken. Every other form returns H:X unchanged.
- R6: The call writes twice, in consecutive cycles. The return address low byte goes to SP, then the high byte goes to SP-1. `sp_out` is SP-2. The compare forms leave SP unchanged.
- R7: For the call, the return address is `pc_in`+1 and the displacement is the byte at `pc_in`. `pc_out` is the return address plus the sign-extended displacement, and `taken` is 1.
- R8: `done` is high for exactly one cycle and `busy` is high from the cycle after `start` until `done`. A `start` while busy is ignored and does not change the result.
- R9: All PC, index and stack arithmetic wraps modulo 65536.
- R10: `wr_en` is asserted only in the two push cycles of a call; a compare form never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 8 | Opcode byte |
| pfx | input | 1 | A prefix byte preceded the opcode |
| pc_in | input | 16 | Address of the byte after the opcode |
| a_in | input | 8 | Accumulator value |
| hx_in | input | 16 | H:X index value (X is the low byte) |
| sp_in | input | 16 | Stack pointer value |
| pf_en | output | 1 | Program-byte fetch strobe |
| pf_addr | output | 16 | Program-byte address |
| pf_data | input | 8 | Program byte, same-cycle |
| rd_en | output | 1 | Data read strobe |
| rd_addr | output | 16 | Data read address |
| rd_data | input | 8 | Data read byte, same-cycle |
| wr_en | output | 1 | Data write strobe |
| wr_addr | output | 16 | Data write address |
| wr_data | output | 8 | Data write byte |
| pc_out | output | 16 | New program counter, valid with done |
| hx_out | output | 16 | New H:X, valid with done |
| sp_out | output | 16 | New stack pointer, valid with done |
| taken | output | 1 | Redirect happened, valid with done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the state machine takes a wrong path, `done` arrives a cycle early or late. This shows at the port in the very operation where it happens, and the bench counts the edges between `start` and `done` for every form. A mis-latched displacement, a wrong operand address or a missed increment shows in `pc_out`, `taken` or `hx_out` in the `done` cycle. The bench arranges each operand so that equal and unequal cases alternate. A stale or wrongly stepped stack pointer shows on the write port within two cycles of `start`, and again in `sp_out`.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_PUSH_LO, S_PUSH_HI, S_FETCH1,
        S_FETCH2, S_READ, S_PAD, S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        F_NONE, F_DIR, F_IMMA, F_IMMX, F_IX1P, F_IXP, F_SP1, F_CALL
    } form_t;

    localparam logic [7:0] OP_DIR  = 8'h31;
    localparam logic [7:0] OP_IMMA = 8'h41;
    localparam logic [7:0] OP_IMMX = 8'h51;
    localparam logic [7:0] OP_IX1P = 8'h61;
    localparam logic [7:0] OP_IXP  = 8'h71;
    localparam logic [7:0] OP_CALL = 8'hAD;

    // cycles from the start edge to the done cycle (total count minus one)
    function automatic logic [2:0] form_latency(form_t f);
        case (f)
            F_DIR:   return 3'd4;
            F_IMMA:  return 3'd3;
            F_IMMX:  return 3'd3;
            F_IX1P:  return 3'd4;
            F_IXP:   return 3'd4;
            F_SP1:   return 3'd5;
            F_CALL:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cbs_decode.sv
module cbs_decode
    import cbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op,
    input  logic              pfx,
    output form_t             form,
    output logic              valid
);

    always_comb begin
        form = F_NONE;
        if (pfx) begin
            if (op == OP_IX1P) form = F_SP1;
        end else begin
            case (op)
                OP_DIR:  form = F_DIR;
                OP_IMMA: form = F_IMMA;
                OP_IMMX: form = F_IMMX;
                OP_IX1P: form = F_IX1P;
                OP_IXP:  form = F_IXP;
                OP_CALL: form = F_CALL;
                default: form = F_NONE;
            endcase
        end
        valid = (form != F_NONE);
    end

endmodule

// File: rtl/cbs_agen.sv
module cbs_agen
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  form_t             form,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] hx,
    input  logic [ADDR_W-1:0] sp,
    input  logic [DATA_W-1:0] offs,
    input  logic [DATA_W-1:0] rel,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] target_pc
);

    localparam int EXT_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] ONE = 1;
    localparam logic [ADDR_W-1:0] TWO = 2;

    logic [ADDR_W-1:0] offs_z;
    logic [ADDR_W-1:0] rel_s;

    assign offs_z = {{EXT_W{1'b0}}, offs};
    assign rel_s  = {{EXT_W{rel[DATA_W-1]}}, rel};

    always_comb begin
        case (form)
            F_DIR:   rd_addr = offs_z;
            F_IX1P:  rd_addr = hx + offs_z;
            F_SP1:   rd_addr = sp + offs_z;
            default: rd_addr = hx;
        endcase
        next_pc   = (form == F_IXP || form == F_CALL) ? pc + ONE : pc + TWO;
        target_pc = next_pc + rel_s;
    end

endmodule

// File: rtl/cmpbr_call_seq.sv
module cmpbr_call_seq
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op,
    input  logic              pfx,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [ADDR_W-1:0] hx_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              pf_en,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic [DATA_W-1:0] pf_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] hx_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              taken,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ONE = 1;

    seq_state_t state, nxt;
    form_t      dec_form, form_r;
    logic       dec_valid;

    logic [ADDR_W-1:0] pc_r, hx_r, sp_r, pc_o, hx_o;
    logic [DATA_W-1:0] a_r, b1_r, rel_r;
    logic              taken_r;

    logic [DATA_W-1:0] rel_now, opnd, cmp_reg;
    logic [ADDR_W-1:0] agen_rd, next_pc, target_pc;
    logic              is_imm, post_inc, is_eq, accept, commit_cmp, commit_call;

    cbs_decode #(.DATA_W(DATA_W)) u_dec (
        .op    (op),
        .pfx   (pfx),
        .form  (dec_form),
        .valid (dec_valid)
    );

    cbs_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agen (
        .form      (form_r),
        .pc        (pc_r),
        .hx        (hx_r),
        .sp        (sp_r),
        .offs      (b1_r),
        .rel       (rel_now),
        .rd_addr   (agen_rd),
        .next_pc   (next_pc),
        .target_pc (target_pc)
    );

    assign accept      = (state == S_IDLE) && start && dec_valid;
    assign is_imm      = (form_r == F_IMMA) || (form_r == F_IMMX);
    assign post_inc    = (form_r == F_IX1P) || (form_r == F_IXP);
    assign rel_now     = (state == S_READ) ? rel_r : pf_data;
    assign opnd        = (state == S_READ) ? rd_data : b1_r;
    assign cmp_reg     = (form_r == F_IMMX) ? hx_r[DATA_W-1:0] : a_r;
    assign is_eq       = (cmp_reg == opnd);
    assign commit_cmp  = (state == S_READ) || (state == S_FETCH2 && is_imm);
    assign commit_call = (state == S_FETCH1) && (form_r == F_CALL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (accept) nxt = (dec_form == F_CALL) ? S_PUSH_LO : S_FETCH1;
            S_PUSH_LO: nxt = S_PUSH_HI;
            S_PUSH_HI: nxt = S_FETCH1;
            S_FETCH1:  if (form_r == F_CALL)     nxt = S_DONE;
                       else if (form_r == F_IXP) nxt = S_READ;
                       else                      nxt = S_FETCH2;
            S_FETCH2:  nxt = is_imm ? S_DONE : S_READ;
            S_READ:    nxt = (form_r == F_IXP || form_r == F_SP1) ? S_PAD : S_DONE;
            S_PAD:     nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            form_r  <= F_NONE;
            pc_r    <= '0;
            hx_r    <= '0;
            sp_r    <= '0;
            a_r     <= '0;
            b1_r    <= '0;
            rel_r   <= '0;
            pc_o    <= '0;
            hx_o    <= '0;
            taken_r <= 1'b0;
        end else begin
            if (accept) begin
                form_r <= dec_form;
                pc_r   <= pc_in;
                hx_r   <= hx_in;
                sp_r   <= sp_in;
                a_r    <= a_in;
            end
            if (state == S_FETCH1) begin
                b1_r  <= pf_data;
                rel_r <= pf_data;
            end
            if (state == S_FETCH2) rel_r <= pf_data;
            if (wr_en) sp_r <= sp_r - ONE;
            if (commit_cmp) begin
                taken_r <= is_eq;
                pc_o    <= is_eq ? target_pc : next_pc;
                hx_o    <= post_inc ? hx_r + ONE : hx_r;
            end
            if (commit_call) begin
                taken_r <= 1'b1;
                pc_o    <= target_pc;
                hx_o    <= hx_r;
            end
        end
    end

    // outputs
    always_comb begin
        pf_en   = (state == S_FETCH1) || (state == S_FETCH2);
        pf_addr = (state == S_FETCH2) ? pc_r + ONE : pc_r;
        rd_en   = (state == S_READ);
        rd_addr = agen_rd;
        wr_en   = (state == S_PUSH_LO) || (state == S_PUSH_HI);
        wr_addr = sp_r;
        wr_data = (state == S_PUSH_LO) ? next_pc[DATA_W-1:0] : next_pc[2*DATA_W-1:DATA_W];
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        pc_out  = pc_o;
        hx_out  = hx_o;
        sp_out  = sp_r;
        taken   = taken_r;
    end

    // cycle counter for the latency check
    logic [2:0] elapsed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              elapsed <= 3'd0;
        else if (state == S_IDLE) elapsed <= 3'd1;
        else                     elapsed <= elapsed + 3'd1;
    end

    a_r1_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !dec_valid) |=> !busy);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (elapsed == form_latency(form_r)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |=> (wr_en && wr_addr == $past(wr_addr) - ONE));

    a_r10_write_only_call: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (form_r == F_CALL));

    a_r5_hx_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !post_inc) |-> (hx_out == hx_r));

endmodule

// File: tb/sim_cmpbr_call_seq.sv
`timescale 1ns/1ps
module sim_cmpbr_call_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op = '0;
    logic        pfx = 1'b0;
    logic [15:0] pc_in = '0, hx_in = '0, sp_in = '0;
    logic [7:0]  a_in = '0;
    logic        pf_en, rd_en, wr_en, taken, busy, done;
    logic [15:0] pf_addr, rd_addr, wr_addr, pc_out, hx_out, sp_out;
    logic [7:0]  pf_data, rd_data, wr_data;

    logic [15:0] v_pc = '0;
    logic [7:0]  v_b0 = '0, v_b1 = '0;

    int n_chk = 0;
    int n_fail = 0;
    int wcnt = 0;
    logic [15:0] w_addr [2];
    logic [7:0]  w_data [2];

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign pf_data = (pf_addr == v_pc) ? v_b0 : (pf_addr == v_pc + 16'd1) ? v_b1 : 8'hEE;
    assign rd_data = memf(rd_addr);

    always @(negedge clk) begin
        if (wr_en) begin
            if (wcnt < 2) begin
                w_addr[wcnt] = wr_addr;
                w_data[wcnt] = wr_data;
            end
            wcnt = wcnt + 1;
        end
    end

    cmpbr_call_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pfx(pfx),
        .pc_in(pc_in), .a_in(a_in), .hx_in(hx_in), .sp_in(sp_in),
        .pf_en(pf_en), .pf_addr(pf_addr), .pf_data(pf_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pc_out(pc_out), .hx_out(hx_out), .sp_out(sp_out),
        .taken(taken), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] o, input bit p, input logic [15:0] pc,
                       input logic [15:0] hx0, input logic [15:0] sp,
                       input logic [7:0] b0, input logic [7:0] b1,
                       input bit eq, input bit poke);
        bit is_call, ixp, ix1p, sp1, dir, immx;
        logic [15:0] hx, nx, sx, epc, ehx, esp;
        logic [7:0]  opnd, a, rel, rg;
        bit tk;
        int lat, n;
        hx = hx0;
        is_call = (o == 8'hAD) && !p;
        ixp  = (o == 8'h71) && !p;
        ix1p = (o == 8'h61) && !p;
        sp1  = (o == 8'h61) && p;
        dir  = (o == 8'h31) && !p;
        immx = (o == 8'h51) && !p;
        if (immx) hx[7:0] = eq ? b0 : ~b0;
        if (dir)       opnd = memf({8'h00, b0});
        else if (ix1p) opnd = memf(hx + {8'h00, b0});
        else if (ixp)  opnd = memf(hx);
        else if (sp1)  opnd = memf(sp + {8'h00, b0});
        else           opnd = b0;
        a   = eq ? opnd : opnd ^ 8'h01;
        rel = (ixp || is_call) ? b0 : b1;
        nx  = (ixp || is_call) ? pc + 16'd1 : pc + 16'd2;
        sx  = {{8{rel[7]}}, rel};
        rg  = immx ? hx[7:0] : a;
        tk  = is_call ? 1'b1 : (rg == opnd);
        epc = tk ? nx + sx : nx;
        ehx = (ixp || ix1p) ? hx + 16'd1 : hx;
        esp = is_call ? sp - 16'd2 : sp;
        lat = sp1 ? 5 : ((o == 8'h41 || o == 8'h51) ? 3 : 4);

        @(negedge clk);
        v_pc = pc; v_b0 = b0; v_b1 = b1;
        op = o; pfx = p; pc_in = pc; hx_in = hx; sp_in = sp; a_in = a;
        wcnt = 0;
        start = 1'b1;
        n = 0;
        while (n < 12) begin
            @(negedge clk);
            n++;
            if (n == 1 && poke) begin
                start = 1'b1; op = 8'hAD; pfx = 1'b0; pc_in = 16'h7777;
            end else start = 1'b0;
            if (done) break;
        end
        chk(n == lat, "R2", "latency", n, lat);
        chk(taken == tk, "R4", "taken", taken, tk);
        if (is_call) begin
            chk(pc_out == epc, "R7", "call pc", pc_out, epc);
            chk(wcnt == 2 && w_addr[0] == sp && w_data[0] == nx[7:0], "R6", "push lo",
                {w_addr[0], w_data[0]}, {sp, nx[7:0]});
            chk(w_addr[1] == sp - 16'd1 && w_data[1] == nx[15:8], "R6", "push hi",
                {w_addr[1], w_data[1]}, {sp - 16'd1, nx[15:8]});
        end else begin
            chk(pc_out == epc, "R3", "branch pc", pc_out, epc);
            chk(wcnt == 0, "R10", "write count", wcnt, 0);
        end
        chk(hx_out == ehx, "R5", "hx", hx_out, ehx);
        chk(sp_out == esp, "R6", "sp", sp_out, esp);
        @(negedge clk);
        chk(!done && !busy, "R8", "done width", {done, busy}, 0);
        start = 1'b0;
    endtask

    localparam int NV = 13;
    localparam logic [7:0]  V_OP  [NV] = '{8'h31, 8'h31, 8'h41, 8'h51, 8'h51, 8'h61, 8'h61,
                                           8'h71, 8'h71, 8'h61, 8'h61, 8'hAD, 8'hAD};
    localparam bit          V_PFX [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam logic [15:0] V_PC  [NV] = '{16'h1000, 16'h1000, 16'h2000, 16'h2100, 16'h2100,
                                           16'h3000, 16'h3000, 16'h4000, 16'h4000, 16'h5000,
                                           16'h5000, 16'h6000, 16'h6000};
    localparam logic [15:0] V_HX  [NV] = '{16'h1234, 16'h1234, 16'h0000, 16'h0033, 16'h0033,
                                           16'h0100, 16'h0100, 16'h0200, 16'h0200, 16'h0000,
                                           16'h0000, 16'h0000, 16'h0000};
    localparam logic [15:0] V_SP  [NV] = '{16'h00F0, 16'h00F0, 16'h00F0, 16'h00F0, 16'h00F0,
                                           16'h00F0, 16'h00F0, 16'h00F0, 16'h00F0, 16'h0180,
                                           16'h0180, 16'h0180, 16'h01F0};
    localparam logic [7:0]  V_B0  [NV] = '{8'h40, 8'h40, 8'h7C, 8'h44, 8'h44, 8'h10, 8'h10,
                                           8'h22, 8'hF0, 8'h03, 8'h03, 8'h7F, 8'h80};
    localparam logic [7:0]  V_B1  [NV] = '{8'h05, 8'h05, 8'hFE, 8'h08, 8'h08, 8'h80, 8'h80,
                                           8'h00, 8'h00, 8'h10, 8'h10, 8'h00, 8'h00};
    localparam bit          V_EQ  [NV] = '{1, 0, 1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 1};

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en && !pf_en, "R8", "reset outputs",
            {busy, done, wr_en, pf_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R8", "idle after reset", {busy, done}, 0);

        for (int i = 0; i < NV; i++)
            run(V_OP[i], V_PFX[i], V_PC[i], V_HX[i], V_SP[i], V_B0[i], V_B1[i], V_EQ[i], 1'b0);

        // R1: unsupported opcode and a prefix on a non-prefixable opcode
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            op = (k == 0) ? 8'h20 : 8'h31;
            pfx = (k == 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!busy, "R1", "rejected opcode busy", busy, 0);
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (done || busy) chk(1'b0, "R1", "rejected opcode ran", {done, busy}, 0);
            end
        end

        // R8: start while busy is ignored
        run(8'h41, 1'b0, 16'h2200, 16'h0000, 16'h00F0, 8'h19, 8'h04, 1'b1, 1'b1);

        // R9: wrap of pc and index, and of the stack during a call
        run(8'h71, 1'b0, 16'hFFFF, 16'hFFFF, 16'h00F0, 8'h05, 8'h00, 1'b1, 1'b0);
        chk(hx_out == 16'h0000 && pc_out == 16'h0005, "R9", "index and pc wrap",
            {hx_out, pc_out}, 32'h0000_0005);
        run(8'hAD, 1'b0, 16'hFFFE, 16'h0000, 16'h0001, 8'h10, 8'h00, 1'b1, 1'b0);
        chk(sp_out == 16'hFFFF && w_addr[1] == 16'h0000 && pc_out == 16'h000F, "R9",
            "stack and call wrap", {sp_out, pc_out}, 32'hFFFF_000F);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule